// File: doc/BRIEF.md
# Registered Parity Bus Transceiver

This block moves data between two ports, A and B, in both directions at once. Each port carries a number of byte lanes, and each lane has a parity bit beside it. Each direction has a storage stage. The stage passes data straight through while its latch enable is high. When the enable is low it holds its contents, and it loads a lane on a rising clock edge only while that lane's clock enable is high.

A mode input picks one of two behaviours for both directions. In generate mode, every outgoing lane gets parity computed from its stored byte, and every incoming lane on both ports is checked. In feed-through mode, the stored parity bit is passed on unchanged and the error flags stay inactive. A polarity input selects odd or even parity. Each direction has its own output enable, and the tri-state pads are modelled as separate data-in, data-out and drive-enable signals. A released side presents zeros on its output vectors.

Reset is synchronous and active high. It clears both storage stages and forces every error flag inactive (high).

Top module: `parity_xcvr`

## Requirements
- R1: While `rst` is high at a rising edge, that edge clears every stored lane of both directions and sets all error flags to 1. Afterwards, with both latch enables and all clock enables low, the outputs show zero data.
- R2: While a direction's latch enable is high, its output data follows its input data in the same cycle, with no clock edge needed.
- R3: While a direction's latch enable is low and a lane's clock enable is low, that lane's output holds the value that was present on the last rising edge that loaded it, whatever the input does.
- R4: While the latch enable is low, a rising edge with clock enable bit i high loads lane i (bits 8i+7..8i) from the input. Lanes whose clock enable is low keep their contents.
- R5: In generate mode (`gen_mode`=1), each outgoing parity bit equals the XOR of its lane's output byte XOR `odd_par`. So with `odd_par`=1, the nine bits of a lane hold an odd number of ones, and with `odd_par`=0 an even number.
- R6: In feed-through mode (`gen_mode`=0), each outgoing parity bit is the stored or passed incoming parity bit, and from the next edge on all error flags read 1.
- R7: In generate mode, error flag bit i of a port goes low on the edge after that port's incoming lane i has a XOR of its 8 data bits and its parity bit that differs from `odd_par`. Otherwise it reads 1. The two ports are checked independently.
- R8: When a direction's drive input is low, that side's output enable is low and its data and parity outputs are zero. When the drive input is high, the output enable is high.
- R9: The controls of one direction (latch enable, clock enables, drive) have no effect on the other direction's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both storage stages and the error flags |
| rst | input | 1 | Synchronous active-high reset |
| gen_mode | input | 1 | 1: generate and check parity, 0: feed-through |
| odd_par | input | 1 | 1: odd parity, 0: even parity |
| a_din | input | 16 | Data arriving at port A |
| a_pin | input | 2 | Parity arriving at port A, one bit per lane |
| b_din | input | 16 | Data arriving at port B |
| b_pin | input | 2 | Parity arriving at port B, one bit per lane |
| ab_le | input | 1 | A-to-B latch enable |
| ab_cke | input | 2 | A-to-B per-lane clock enables |
| ab_drive | input | 1 | Enables the B-side outputs |
| ba_le | input | 1 | B-to-A latch enable |
| ba_cke | input | 2 | B-to-A per-lane clock enables |
| ba_drive | input | 1 | Enables the A-side outputs |
| b_dout | output | 16 | Data driven onto port B |
| b_pout | output | 2 | Parity driven onto port B |
| b_oe | output | 1 | Port B pad drive enable |
| a_dout | output | 16 | Data driven onto port A |
| a_pout | output | 2 | Parity driven onto port A |
| a_oe | output | 1 | Port A pad drive enable |
| a_err_n | output | 2 | Active-low per-lane parity error for port A input |
| b_err_n | output | 2 | Active-low per-lane parity error for port B input |

## Verification
The bench first loads a value while the latch is open. It then closes the latch and changes the input without a clock edge. A stage that captures only on edges, or that keeps following the input, shows the wrong byte here. Clock enables are driven one lane at a time, so a design that shares one enable across lanes corrupts the other byte. Parity is checked with lane values of both weights under both polarities, which exposes an inverted polarity term. Bad incoming parity is placed on one lane and one port at a time, so a flag wired to the wrong lane or side, or one that stays live in feed-through mode, shows up.

// File: rtl/pxcv_pkg.sv
package pxcv_pkg;
  typedef enum logic {
    MODE_FEED = 1'b0,
    MODE_GEN  = 1'b1
  } pmode_e;
endpackage

// File: rtl/pxcv_stage.sv
// Per-direction storage: transparent while le is high, else per-lane
// edge capture gated by that lane's clock enable.
module pxcv_stage #(
  parameter int LANES  = 2,
  parameter int BYTE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    le,
  input  logic [LANES-1:0]        cke,
  input  logic [LANES*BYTE_W-1:0] din,
  input  logic [LANES-1:0]        pin,
  output logic [LANES*BYTE_W-1:0] dout,
  output logic [LANES-1:0]        pout
);
  localparam int W = LANES * BYTE_W;

  logic [W-1:0]     held_d;
  logic [LANES-1:0] held_p;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic load;
    assign load = le | cke[g];

    always_ff @(posedge clk) begin
      if (rst) begin
        held_d[g*BYTE_W +: BYTE_W] <= '0;
        held_p[g]                  <= 1'b0;
      end else if (load) begin
        held_d[g*BYTE_W +: BYTE_W] <= din[g*BYTE_W +: BYTE_W];
        held_p[g]                  <= pin[g];
      end
    end

    assign dout[g*BYTE_W +: BYTE_W] = le ? din[g*BYTE_W +: BYTE_W] : held_d[g*BYTE_W +: BYTE_W];
    assign pout[g]                  = le ? pin[g] : held_p[g];

    // R1: reset clears the lane
    p_rst_clear_r1: assert property (@(posedge clk)
      rst |=> (held_d[g*BYTE_W +: BYTE_W] == '0 && held_p[g] == 1'b0));

    // R3: closed latch without clock enable holds the lane
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
      (!le && !cke[g]) |=> $stable({held_p[g], held_d[g*BYTE_W +: BYTE_W]}));

    // R4: an enabled edge loads the lane from the input
    p_capture_r4: assert property (@(posedge clk) disable iff (rst)
      (!le && cke[g]) |=> (held_d[g*BYTE_W +: BYTE_W] == $past(din[g*BYTE_W +: BYTE_W])));
  end
endmodule

// File: rtl/pxcv_parity.sv
// Per-direction parity: checks the incoming port, generates or forwards
// the outgoing parity, and gates the outgoing side by its drive enable.
module pxcv_parity
  import pxcv_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int BYTE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  pmode_e                  mode,
  input  logic                    odd_par,
  input  logic                    drive,
  input  logic [LANES*BYTE_W-1:0] chk_d,
  input  logic [LANES-1:0]        chk_p,
  input  logic [LANES*BYTE_W-1:0] src_d,
  input  logic [LANES-1:0]        src_p,
  output logic [LANES*BYTE_W-1:0] out_d,
  output logic [LANES-1:0]        out_p,
  output logic                    oe,
  output logic [LANES-1:0]        err_n
);
  localparam int W = LANES * BYTE_W;

  logic [LANES-1:0] par_sel;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic rx_sum;
    assign rx_sum     = ^{chk_d[g*BYTE_W +: BYTE_W], chk_p[g]};
    assign par_sel[g] = (mode == MODE_GEN) ? ((^src_d[g*BYTE_W +: BYTE_W]) ^ odd_par) : src_p[g];

    always_ff @(posedge clk) begin
      if (rst)                  err_n[g] <= 1'b1;
      else if (mode == MODE_GEN) err_n[g] <= (rx_sum == odd_par);
      else                       err_n[g] <= 1'b1;
    end

    // R5: generated lane carries the selected parity sense
    p_gen_sense_r5: assert property (@(posedge clk) disable iff (rst)
      (mode == MODE_GEN && drive) |-> ((^{out_d[g*BYTE_W +: BYTE_W], out_p[g]}) == odd_par));
  end

  assign out_d = drive ? src_d : {W{1'b0}};
  assign out_p = drive ? par_sel : {LANES{1'b0}};
  assign oe    = drive;

  // R6: feed-through keeps every flag inactive
  p_feed_flags_r6: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_FEED) |=> (&err_n));

  // R8: a released side shows zeros
  p_release_r8: assert property (@(posedge clk) disable iff (rst)
    !drive |-> (out_d == '0 && out_p == '0 && !oe));
endmodule

// File: rtl/parity_xcvr.sv
module parity_xcvr
  import pxcv_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int BYTE_W = 8,
  localparam int W     = LANES * BYTE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             gen_mode,
  input  logic             odd_par,
  input  logic [W-1:0]     a_din,
  input  logic [LANES-1:0] a_pin,
  input  logic [W-1:0]     b_din,
  input  logic [LANES-1:0] b_pin,
  input  logic             ab_le,
  input  logic [LANES-1:0] ab_cke,
  input  logic             ab_drive,
  input  logic             ba_le,
  input  logic [LANES-1:0] ba_cke,
  input  logic             ba_drive,
  output logic [W-1:0]     b_dout,
  output logic [LANES-1:0] b_pout,
  output logic             b_oe,
  output logic [W-1:0]     a_dout,
  output logic [LANES-1:0] a_pout,
  output logic             a_oe,
  output logic [LANES-1:0] a_err_n,
  output logic [LANES-1:0] b_err_n
);
  pmode_e mode;
  assign mode = gen_mode ? MODE_GEN : MODE_FEED;

  logic [W-1:0]     ab_d, ba_d;
  logic [LANES-1:0] ab_p, ba_p;

  pxcv_stage #(.LANES(LANES), .BYTE_W(BYTE_W)) u_ab_stage (
    .clk(clk), .rst(rst), .le(ab_le), .cke(ab_cke),
    .din(a_din), .pin(a_pin), .dout(ab_d), .pout(ab_p)
  );

  pxcv_stage #(.LANES(LANES), .BYTE_W(BYTE_W)) u_ba_stage (
    .clk(clk), .rst(rst), .le(ba_le), .cke(ba_cke),
    .din(b_din), .pin(b_pin), .dout(ba_d), .pout(ba_p)
  );

  pxcv_parity #(.LANES(LANES), .BYTE_W(BYTE_W)) u_ab_par (
    .clk(clk), .rst(rst), .mode(mode), .odd_par(odd_par), .drive(ab_drive),
    .chk_d(a_din), .chk_p(a_pin), .src_d(ab_d), .src_p(ab_p),
    .out_d(b_dout), .out_p(b_pout), .oe(b_oe), .err_n(a_err_n)
  );

  pxcv_parity #(.LANES(LANES), .BYTE_W(BYTE_W)) u_ba_par (
    .clk(clk), .rst(rst), .mode(mode), .odd_par(odd_par), .drive(ba_drive),
    .chk_d(b_din), .chk_p(b_pin), .src_d(ba_d), .src_p(ba_p),
    .out_d(a_dout), .out_p(a_pout), .oe(a_oe), .err_n(b_err_n)
  );

  // R2: open latch with drive passes A data straight to B
  p_transparent_r2: assert property (@(posedge clk) disable iff (rst)
    (ab_le && ab_drive) |-> (b_dout == a_din));

  // R9: A-to-B controls leave the held B-to-A output untouched
  p_isolate_r9: assert property (@(posedge clk) disable iff (rst)
    (!ba_le && ba_cke == '0 && ba_drive && $past(ba_drive) && !$past(ba_le) && !$past(rst))
      |-> $stable(a_dout));
endmodule

// File: tb/tb_parity_xcvr.sv
`timescale 1ns/1ps
module tb_parity_xcvr;
  localparam int LANES = 2;
  localparam int BW    = 8;
  localparam int W     = LANES * BW;

  logic clk = 1'b0;
  logic rst;
  logic gen_mode, odd_par;
  logic [W-1:0] a_din, b_din;
  logic [LANES-1:0] a_pin, b_pin;
  logic ab_le, ba_le, ab_drive, ba_drive;
  logic [LANES-1:0] ab_cke, ba_cke;
  logic [W-1:0] b_dout, a_dout;
  logic [LANES-1:0] b_pout, a_pout, a_err_n, b_err_n;
  logic b_oe, a_oe;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  parity_xcvr #(.LANES(LANES), .BYTE_W(BW)) dut (
    .clk(clk), .rst(rst), .gen_mode(gen_mode), .odd_par(odd_par),
    .a_din(a_din), .a_pin(a_pin), .b_din(b_din), .b_pin(b_pin),
    .ab_le(ab_le), .ab_cke(ab_cke), .ab_drive(ab_drive),
    .ba_le(ba_le), .ba_cke(ba_cke), .ba_drive(ba_drive),
    .b_dout(b_dout), .b_pout(b_pout), .b_oe(b_oe),
    .a_dout(a_dout), .a_pout(a_pout), .a_oe(a_oe),
    .a_err_n(a_err_n), .b_err_n(b_err_n)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] gpar(input logic [15:0] d, input logic odd);
    return {(^d[15:8]) ^ odd, (^d[7:0]) ^ odd};
  endfunction

  task automatic t_reset();
    rst = 1'b1; step(); step(); rst = 1'b0; #1;
    chk("R1 b data", b_dout, 16'h0);
    chk("R1 a data", a_dout, 16'h0);
    chk("R1 b parity even", b_pout, 2'b00);
    chk("R1 flags", {a_err_n, b_err_n}, 4'b1111);
  endtask

  task automatic t_transparent();
    ab_le = 1'b1; a_din = 16'h3701; #1;
    chk("R2 follow", b_dout, 16'h3701);
    chk("R5 even gen", b_pout, gpar(16'h3701, 1'b0));
    a_din = 16'hC3F0; #1;
    chk("R2 follow again", b_dout, 16'hC3F0);
    chk("R5 even gen 2", b_pout, gpar(16'hC3F0, 1'b0));
  endtask

  task automatic t_latch_hold();
    ab_le = 1'b1; a_din = 16'h5AA5; step();
    ab_le = 1'b0; a_din = 16'h1234; #1;
    chk("R3 hold after close", b_dout, 16'h5AA5);
    step();
    chk("R3 hold over edge", b_dout, 16'h5AA5);
  endtask

  task automatic t_clocked();
    ab_cke = 2'b01; a_din = 16'h9E7C; step();
    ab_cke = 2'b00;
    chk("R4 lane0 only", b_dout, 16'h5A7C);
    a_din = 16'h4411; ab_cke = 2'b10; step();
    ab_cke = 2'b00; a_din = 16'h0000; #1;
    chk("R4 lane1 only", b_dout, 16'h447C);
  endtask

  task automatic t_odd();
    odd_par = 1'b1; #1;
    chk("R5 odd gen", b_pout, gpar(16'h447C, 1'b1));
    odd_par = 1'b0; #1;
  endtask

  task automatic t_feed();
    gen_mode = 1'b0; ab_le = 1'b1; a_din = 16'h0101; a_pin = 2'b10; step();
    chk("R6 parity passed", b_pout, 2'b10);
    chk("R6 flags inactive", a_err_n, 2'b11);
    a_pin = 2'b01; #1;
    chk("R6 parity passed 2", b_pout, 2'b01);
    gen_mode = 1'b1; ab_le = 1'b0; a_din = 16'h0; a_pin = 2'b00; step();
  endtask

  task automatic t_errors();
    a_din = 16'h0001; a_pin = 2'b00; step();
    chk("R7 a lane0 err", a_err_n, 2'b10);
    chk("R7 b clean", b_err_n, 2'b11);
    a_din = 16'h0; b_din = 16'h0300; b_pin = 2'b10; step();
    chk("R7 b lane1 err", b_err_n, 2'b01);
    chk("R7 a clean", a_err_n, 2'b11);
    odd_par = 1'b1; step();
    chk("R7 odd a both err", a_err_n, 2'b00);
    chk("R7 odd b lane0 err", b_err_n, 2'b10);
    odd_par = 1'b0; b_din = 16'h0; b_pin = 2'b00; step();
  endtask

  task automatic t_release();
    ab_drive = 1'b0; #1;
    chk("R8 b data zero", b_dout, 16'h0);
    chk("R8 b parity zero", b_pout, 2'b00);
    chk("R8 b oe low", b_oe, 1'b0);
    chk("R8 a oe high", a_oe, 1'b1);
    ab_drive = 1'b1; #1;
    chk("R8 b oe high", b_oe, 1'b1);
  endtask

  task automatic t_isolation();
    ba_le = 1'b1; b_din = 16'hBEEF; step();
    ba_le = 1'b0; b_din = 16'h0; #1;
    chk("R9 ba held", a_dout, 16'hBEEF);
    ab_le = 1'b1; ab_cke = 2'b11; ab_drive = 1'b0; a_din = 16'hFFFF; step();
    chk("R9 ba unaffected", a_dout, 16'hBEEF);
    chk("R9 ba parity", a_pout, gpar(16'hBEEF, 1'b0));
    ab_le = 1'b0; ab_cke = 2'b00; ab_drive = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; gen_mode = 1'b1; odd_par = 1'b0;
    a_din = '0; b_din = '0; a_pin = '0; b_pin = '0;
    ab_le = 1'b0; ba_le = 1'b0; ab_cke = '0; ba_cke = '0;
    ab_drive = 1'b1; ba_drive = 1'b1;
    #2;
    t_reset();
    t_transparent();
    t_latch_hold();
    t_clocked();
    t_odd();
    t_feed();
    t_errors();
    t_release();
    t_isolation();
    step();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule